// File: doc/BRIEF.md
# Serial port clock generator

This block makes the bit-rate enable for one serial channel. The channel can run as an asynchronous UART or as a clock-synchronous serial port. Everything runs on one main clock. A free-running prescaler provides four count-enable rates: the main clock undivided, divided by 2, by 8, or by 32. One of them is chosen and counted down by a reload divider programmed with an 8-bit value `n`, so the divider pulses once every `n+1` enables.

A post stage shapes that pulse for the chosen serial mode:
- **UART:** a divide by 16 gives the shared transmit and receive bit enable.
- **Synchronous, internal clock:** a toggle gives a divide by 2, and the toggling level is offered to the clock pin.
- **Synchronous, external clock:** the clock pin is synchronized and edge-detected. The divider is ignored in this case.

A polarity control sets which edge the transfer logic acts on. A separate pair of controls assigns the shared flow-control pin to a clear-to-send input, a request-to-send output, or neither.

The bit clock leaves the block as a one-cycle enable, `bit_tick`, and never as a gated clock. All outputs come from registers.

Top module: `serclk_gen`

## Requirements
- R1: Reset is synchronous and active-high. While reset is held and in the cycle after it, `bit_tick`, `sclk_oe`, `cts_in_en` and `rts_out_en` are 0. By the second clock edge after release, `sclk_out` equals `clk_pol`.
- R2: `src_sel` picks the count rate, with a prescale factor P. `2'b00` is the fast rate: P=1 when `fast_half`=0 and P=2 when `fast_half`=1. `2'b01` gives P=8 and `2'b10` gives P=32.
- R3: `src_sel`=`2'b11` gives no count enable, so no `bit_tick` is produced in UART or internal-synchronous mode.
- R4: The reload divider pulses once every `reload_n`+1 count enables, for any `reload_n` from 0 to 255.
- R5: `mode` values 3'b010, 3'b100, 3'b101 and 3'b110 select UART. Here `bit_tick` repeats every 16·P·(`reload_n`+1) cycles.
- R6: `mode`=3'b001 with `ext_clk`=0 selects internal synchronous mode. Here `bit_tick` repeats every 2·P·(`reload_n`+1) cycles, `sclk_out` changes level every P·(`reload_n`+1) cycles, and `sclk_oe` is 1.
- R7: `mode`=3'b001 with `ext_clk`=1 gives exactly one `bit_tick` per rising edge of (`clk_pin_in` XOR `clk_pol`), after a two-flop synchronizer. The reload divider has no effect, and `sclk_oe` is 0.
- R8: In internal synchronous mode, `sclk_out` is 1 in every cycle that `bit_tick` is 1; `clk_pol`=1 moves the active edge to the opposite pin transition. Outside that mode, `sclk_out` rests at `clk_pol`.
- R9: `mode` values 3'b000, 3'b011 and 3'b111 produce no `bit_tick`.
- R10: A new `reload_n` written mid-period takes effect at the next reload, so the period in progress completes at the old length.
- R11: `flow_off`=1 drives both `cts_in_en` and `rts_out_en` to 0. Otherwise `flow_rts`=1 sets only `rts_out_en` and `flow_rts`=0 sets only `cts_in_en`. The outputs follow one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 2 | Count-rate select |
| fast_half | input | 1 | Halves the fast rate when 1 |
| reload_n | input | 8 | Reload value n of the divider |
| mode | input | 3 | Serial mode code |
| ext_clk | input | 1 | Synchronous mode takes its clock from the pin when 1 |
| clk_pol | input | 1 | Serial clock polarity |
| clk_pin_in | input | 1 | Clock pin input level |
| flow_off | input | 1 | Disables the flow-control pin function |
| flow_rts | input | 1 | Flow-control pin is RTS output (1) or CTS input (0) |
| bit_tick | output | 1 | One-cycle bit clock enable |
| sclk_out | output | 1 | Clock level to drive on the clock pin |
| sclk_oe | output | 1 | Clock pin output enable |
| cts_in_en | output | 1 | Flow-control pin acts as CTS input |
| rts_out_en | output | 1 | Flow-control pin acts as RTS output |

## Verification
Random UART and internal-synchronous settings are drawn across all three count rates, both fast-rate halvings, both polarities and many reload values. The measured tick interval then shows whether the prescale, the n+1 divide and the 16-or-2 post divide are each applied exactly once. Reload values 0 and 255 probe the ends of the divider. A reload change in mid-period separates deferred loading from immediate loading: the next two half periods are 6 and then 3 cycles. Pin toggling in external mode, with the divider running at full speed, shows that ticks follow the polarity-adjusted pin edges and never the divider. The unused source and mode codes, along with the three flow-control settings, confirm the quiet and exclusive cases.

// File: rtl/serclk_pkg.sv
package serclk_pkg;

  typedef enum logic [1:0] {
    SRC_FAST  = 2'b00,
    SRC_DIV8  = 2'b01,
    SRC_DIV32 = 2'b10,
    SRC_NONE  = 2'b11
  } src_e;

  typedef enum logic [1:0] {
    XF_OFF      = 2'b00,
    XF_UART     = 2'b01,
    XF_SYNC_INT = 2'b10,
    XF_SYNC_EXT = 2'b11
  } xfer_e;

  // Serial mode code to transfer kind; unused codes map to XF_OFF
  function automatic xfer_e decode_xfer(input logic [2:0] mode, input logic ext);
    xfer_e k;
    case (mode)
      3'b001:                         k = ext ? XF_SYNC_EXT : XF_SYNC_INT;
      3'b010, 3'b100, 3'b101, 3'b110: k = XF_UART;
      default:                        k = XF_OFF;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/serclk_prescale.sv
module serclk_prescale
  import serclk_pkg::*;
#(
  parameter int MID_LOG2  = 3,
  parameter int SLOW_LOG2 = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] src_sel,
  input  logic       fast_half,
  output logic       count_en
);

  logic [SLOW_LOG2-1:0] pre_cnt;
  logic                 en_half;
  logic                 en_mid;
  logic                 en_slow;

  always_ff @(posedge clk) begin
    if (rst) pre_cnt <= '0;
    else     pre_cnt <= pre_cnt + 1'b1;
  end

  // Each strobe fires once per its own power-of-two span of the counter
  assign en_half = pre_cnt[0];
  assign en_mid  = &pre_cnt[MID_LOG2-1:0];
  assign en_slow = &pre_cnt;

  always_comb begin
    case (src_e'(src_sel))
      SRC_FAST:  count_en = fast_half ? en_half : 1'b1;
      SRC_DIV8:  count_en = en_mid;
      SRC_DIV32: count_en = en_slow;
      default:   count_en = 1'b0;
    endcase
  end

endmodule

// File: rtl/serclk_reload_div.sv
module serclk_reload_div #(
  parameter int N_W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           count_en,
  input  logic [N_W-1:0] reload_n,
  output logic           div_pulse
);

  logic [N_W-1:0] rem;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem       <= '0;
      div_pulse <= 1'b0;
    end else begin
      div_pulse <= count_en && (rem == '0);
      if (count_en) begin
        // reload_n is sampled only here, so a running period is never cut
        if (rem == '0) rem <= reload_n;
        else           rem <= rem - 1'b1;
      end
    end
  end

  // R4
  pulse_from_enable_chk: assert property (@(posedge clk) disable iff (rst)
    div_pulse |-> $past(count_en));

  // R10
  no_midperiod_load_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(count_en) && ($past(rem) != '0)) |-> (rem == $past(rem) - 1'b1));

endmodule

// File: rtl/serclk_post.sv
module serclk_post
  import serclk_pkg::*;
#(
  parameter int OS_LOG2     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic  clk,
  input  logic  rst,
  input  xfer_e xfer,
  input  logic  div_pulse,
  input  logic  pin_in,
  input  logic  pol,
  output logic  bit_tick,
  output logic  sclk_out
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   ext_lvl;
  logic                   ext_lvl_q;
  logic [OS_LOG2-1:0]     os_cnt;
  logic                   raw;
  logic                   raw_next;
  logic                   tick_next;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin_in};
  end

  assign ext_lvl = sync_q[SYNC_STAGES-1] ^ pol;

  always_comb begin
    raw_next = raw;
    if (xfer != XF_SYNC_INT) raw_next = 1'b0;
    else if (div_pulse)      raw_next = ~raw;
  end

  always_comb begin
    case (xfer)
      XF_UART:     tick_next = div_pulse && (&os_cnt);
      XF_SYNC_INT: tick_next = div_pulse && (raw_next ^ pol);
      XF_SYNC_EXT: tick_next = ext_lvl && !ext_lvl_q;
      default:     tick_next = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_lvl_q <= 1'b0;
      os_cnt    <= '0;
      raw       <= 1'b0;
      bit_tick  <= 1'b0;
      sclk_out  <= 1'b0;
    end else begin
      ext_lvl_q <= ext_lvl;
      raw       <= raw_next;
      bit_tick  <= tick_next;
      sclk_out  <= raw_next ^ pol;
      if (xfer != XF_UART) os_cnt <= '0;
      else if (div_pulse)  os_cnt <= os_cnt + 1'b1;
    end
  end

  // R9
  idle_mode_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer == XF_OFF) |=> !bit_tick);

  // R5
  uart_tick_on_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_tick && $past(xfer == XF_UART)) |-> $past(div_pulse));

  // R8
  sync_tick_high_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_tick && $past(xfer == XF_SYNC_INT)) |-> sclk_out);

endmodule

// File: rtl/serclk_gen.sv
module serclk_gen
  import serclk_pkg::*;
#(
  parameter int N_W         = 8,
  parameter int MID_LOG2    = 3,
  parameter int SLOW_LOG2   = 5,
  parameter int OS_LOG2     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [1:0]     src_sel,
  input  logic           fast_half,
  input  logic [N_W-1:0] reload_n,
  input  logic [2:0]     mode,
  input  logic           ext_clk,
  input  logic           clk_pol,
  input  logic           clk_pin_in,
  input  logic           flow_off,
  input  logic           flow_rts,
  output logic           bit_tick,
  output logic           sclk_out,
  output logic           sclk_oe,
  output logic           cts_in_en,
  output logic           rts_out_en
);

  xfer_e xfer;
  logic  count_en;
  logic  div_pulse;

  assign xfer = decode_xfer(mode, ext_clk);

  serclk_prescale #(
    .MID_LOG2 (MID_LOG2),
    .SLOW_LOG2(SLOW_LOG2)
  ) u_prescale (
    .clk      (clk),
    .rst      (rst),
    .src_sel  (src_sel),
    .fast_half(fast_half),
    .count_en (count_en)
  );

  serclk_reload_div #(
    .N_W(N_W)
  ) u_div (
    .clk      (clk),
    .rst      (rst),
    .count_en (count_en),
    .reload_n (reload_n),
    .div_pulse(div_pulse)
  );

  serclk_post #(
    .OS_LOG2    (OS_LOG2),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_post (
    .clk      (clk),
    .rst      (rst),
    .xfer     (xfer),
    .div_pulse(div_pulse),
    .pin_in   (clk_pin_in),
    .pol      (clk_pol),
    .bit_tick (bit_tick),
    .sclk_out (sclk_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_oe    <= 1'b0;
      cts_in_en  <= 1'b0;
      rts_out_en <= 1'b0;
    end else begin
      sclk_oe    <= (xfer == XF_SYNC_INT);
      cts_in_en  <= !flow_off && !flow_rts;
      rts_out_en <= !flow_off && flow_rts;
    end
  end

  // R3
  no_source_no_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(src_sel) == 2'b11) |-> !div_pulse);

  // R11
  flow_pin_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(cts_in_en && rts_out_en));

endmodule

// File: tb/serclk_gen_tb.sv
`timescale 1ns/1ps
module serclk_gen_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] src_sel = 2'b00;
  logic       fast_half = 1'b0;
  logic [7:0] reload_n = 8'd0;
  logic [2:0] mode = 3'b000;
  logic       ext_clk = 1'b0;
  logic       clk_pol = 1'b1;
  logic       clk_pin_in = 1'b0;
  logic       flow_off = 1'b1;
  logic       flow_rts = 1'b0;
  logic       bit_tick, sclk_out, sclk_oe, cts_in_en, rts_out_en;

  int total = 0;
  int bad = 0;
  int tick_cnt = 0;

  always #4 clk = ~clk;

  serclk_gen u_dut (
    .clk(clk), .rst(rst), .src_sel(src_sel), .fast_half(fast_half),
    .reload_n(reload_n), .mode(mode), .ext_clk(ext_clk), .clk_pol(clk_pol),
    .clk_pin_in(clk_pin_in), .flow_off(flow_off), .flow_rts(flow_rts),
    .bit_tick(bit_tick), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
    .cts_in_en(cts_in_en), .rts_out_en(rts_out_en)
  );

  always @(negedge clk) if (bit_tick) tick_cnt++;

  function automatic int pre_factor(input int s, input int h);
    if (s == 0) return (h != 0) ? 2 : 1;
    if (s == 1) return 8;
    if (s == 2) return 32;
    return 0;
  endfunction

  function automatic int post_factor(input bit uart);
    return uart ? 16 : 2;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_tick(output int cycles);
    cycles = 0;
    do begin
      @(negedge clk);
      cycles++;
    end while (!bit_tick);
  endtask

  task automatic wait_toggle(output int cycles);
    logic s;
    s = sclk_out;
    cycles = 0;
    do begin
      @(negedge clk);
      cycles++;
    end while (sclk_out == s);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic quiet_window(input string tag);
    int start;
    idle(40);
    start = tick_cnt;
    idle(300);
    chk(tick_cnt == start, tag, tick_cnt - start, 0);
  endtask

  initial begin
    #1440000;
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int c, c2, exp, start;
    int uart_codes[4] = '{2, 4, 5, 6};
    void'($urandom(32'd20240517));

    // R1 reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!bit_tick && !sclk_oe && !cts_in_en && !rts_out_en, "R1 reset outputs", 
        {bit_tick, sclk_oe, cts_in_en, rts_out_en}, 0);
    rst = 1'b0;
    idle(2);
    chk(sclk_out == clk_pol, "R1 sclk_out idles at polarity", sclk_out, clk_pol);
    chk(!bit_tick && !cts_in_en && !rts_out_en, "R1 after release", 
        {bit_tick, cts_in_en, rts_out_en}, 0);

    // R11 flow-control pin function
    flow_off = 1'b0; flow_rts = 1'b1; idle(2);
    chk(rts_out_en && !cts_in_en, "R11 rts selected", {cts_in_en, rts_out_en}, 1);
    flow_rts = 1'b0; idle(2);
    chk(cts_in_en && !rts_out_en, "R11 cts selected", {cts_in_en, rts_out_en}, 2);
    flow_off = 1'b1; flow_rts = 1'b1; idle(2);
    chk(!cts_in_en && !rts_out_en, "R11 disabled", {cts_in_en, rts_out_en}, 0);

    // R9 unused mode codes, divider at full speed
    src_sel = 2'b00; fast_half = 1'b0; reload_n = 8'd0; ext_clk = 1'b0;
    mode = 3'b000; quiet_window("R9 mode 000");
    mode = 3'b011; quiet_window("R9 mode 011");
    mode = 3'b111; quiet_window("R9 mode 111");

    // R3 no count source
    src_sel = 2'b11;
    mode = 3'b010; quiet_window("R3 uart with source 11");
    mode = 3'b001; quiet_window("R3 sync with source 11");

    // R4 divider boundaries in UART mode
    src_sel = 2'b00; mode = 3'b100; clk_pol = 1'b0;
    reload_n = 8'd0;
    wait_tick(c); wait_tick(c); wait_tick(c);
    chk(c == 16, "R4 n=0 uart period", c, 16);
    chk(sclk_out == clk_pol, "R8 sclk_out rests in uart", sclk_out, clk_pol);
    reload_n = 8'd255;
    wait_tick(c); wait_tick(c); wait_tick(c);
    chk(c == 4096, "R4 n=255 uart period", c, 4096);

    // R2 R5 R6 R8 random settings
    for (int i = 0; i < 8; i++) begin
      int s, h, pre, post, nmax, n;
      bit u, p;
      s = $urandom % 3; h = $urandom % 2; u = 1'($urandom % 2); p = 1'($urandom % 2);
      pre = pre_factor(s, h); post = post_factor(u);
      nmax = 2000 / (pre * post) - 1;
      if (nmax > 255) nmax = 255;
      if (nmax < 0) nmax = 0;
      n = $urandom % (nmax + 1);
      src_sel = 2'(s); fast_half = 1'(h); reload_n = 8'(n); clk_pol = p;
      ext_clk = 1'b0;
      mode = u ? 3'(uart_codes[$urandom % 4]) : 3'b001;
      exp = pre * (n + 1) * post;
      wait_tick(c); wait_tick(c); wait_tick(c);
      chk(c == exp, u ? "R2 R4 R5 uart period" : "R2 R4 R6 sync period", c, exp);
      if (u) chk(sclk_out == p, "R8 sclk_out rests in uart", sclk_out, p);
      else begin
        chk(sclk_out == 1'b1, "R8 tick with sclk_out high", sclk_out, 1);
        chk(sclk_oe == 1'b1, "R6 clock pin driven", sclk_oe, 1);
      end
    end

    // R6 R10 half period and deferred reload
    src_sel = 2'b00; fast_half = 1'b0; mode = 3'b001; ext_clk = 1'b0; clk_pol = 1'b0;
    reload_n = 8'd5;
    wait_toggle(c); wait_toggle(c); wait_toggle(c);
    chk(c == 6, "R6 half period n=5", c, 6);
    reload_n = 8'd2;
    wait_toggle(c);
    wait_toggle(c2);
    chk(c == 6, "R10 running period keeps old n", c, 6);
    chk(c2 == 3, "R10 new n after reload", c2, 3);

    // R7 external clock, divider pulsing every cycle
    reload_n = 8'd0; ext_clk = 1'b1; clk_pol = 1'b0; clk_pin_in = 1'b0;
    idle(10);
    chk(sclk_oe == 1'b0, "R7 clock pin not driven", sclk_oe, 0);
    start = tick_cnt;
    idle(200);
    chk(tick_cnt == start, "R7 divider ignored", tick_cnt - start, 0);
    start = tick_cnt;
    for (int k = 0; k < 5; k++) begin
      clk_pin_in = 1'b1; idle(6);
      clk_pin_in = 1'b0; idle(6);
    end
    idle(6);
    chk(tick_cnt - start == 5, "R7 ticks on rising pin", tick_cnt - start, 5);
    clk_pol = 1'b1; idle(10);
    start = tick_cnt;
    for (int k = 0; k < 3; k++) begin
      clk_pin_in = 1'b1; idle(6);
      clk_pin_in = 1'b0; idle(6);
    end
    idle(6);
    chk(tick_cnt - start == 3, "R7 R8 ticks on falling pin", tick_cnt - start, 3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule